// File: doc/BRIEF.md
# Slow-Clock Edge Guard Access Scheduler

This block connects a fast register bus to a slow, always-on clock domain. That slow domain must not see an access strobe close to the rising edge of its own clock. The block receives the slow clock level, already synchronized into the fast clock domain. It counts how many fast cycles the low phase and the high phase of that clock last. From these counts it forms two guard bands: a pre-edge band taken from the low-phase width and a post-edge band taken from the high-phase width. Each band is a power-of-two fraction of the width plus a programmable offset.

A requester raises a request level and gives the direction. The scheduler holds the request until the slow clock's current position leaves enough room: the access must end before the pre-edge guard of the next expected rising edge, and the post-edge guard since the last rising edge must have passed. It then drives the grant strobe for a programmed number of cycles and pulses done. Two configuration bits, one for reads and one for writes, release accesses of that direction at once without the guard check.

Top module: `edge_guard_sched`

## Requirements
- R1: Word 0x0 holds the write bypass bit in bit 29, the read bypass bit in bit 28 and a 16-bit hold count in bits 15:0. Words 0x8 (pre-edge) and 0xC (post-edge) each hold a 4-bit ratio code in bits 19:16 and a 16-bit offset in bits 15:0. All other bits read as zero.
- R2: Word 0x4 always reads zero, and writes to it have no effect on any register.
- R3: After reset every register reads zero, and grant and done are low.
- R4: The low width is the number of consecutive fast-clock samples of the slow level at 0, and the high width is the number of consecutive samples at 1. Both widths are refreshed at every level change.
- R5: Each guard equals its offset plus a ratio term. Ratio code 0 gives a term of 0. A code n from 1 to 15 gives the width shifted right by 16-n. The pre-edge guard uses the low width and the post-edge guard uses the high width.
- R6: A non-bypassed request is granted on the first clock edge at which two conditions hold, using the count s of edges since the last rising edge of the slow clock as it stood before that edge. The first condition is (low width + high width - s) > pre-edge guard + hold count. The second is s >= post-edge guard. Grant rises right after that edge.
- R7: A request that never finds an allowed window stays pending without timeout. This includes the case where no full slow period has been measured.
- R8: When the bypass bit for the requested direction is 1, a pending request is granted at the next edge regardless of the window. The bypass bit of the other direction has no effect.
- R9: Grant stays high for hold count + 1 cycles. Then done is high for exactly one cycle with grant low, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| apbSel | input | 1 | Register port select |
| apbEnable | input | 1 | Register port access phase |
| apbWrite | input | 1 | 1 = register write |
| apbAddr | input | 4 | Byte address of the register word |
| apbWdata | input | 32 | Register write data |
| apbRdata | output | 32 | Register read data, valid while selected |
| slowLvl | input | 1 | Synchronized slow clock level |
| accReq | input | 1 | Access request level, held until grant |
| accWrite | input | 1 | Direction of the request, 1 = write |
| accGrant | output | 1 | Access strobe toward the slow domain |
| accDone | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench runs a slow clock of fixed low and high widths. It places a request at every phase position of one period under several guard settings: zero guards, smallest-ratio codes, half and quarter ratios with offsets, and a long hold count. It compares each grant's start edge with an earliest-allowed edge that it computes itself. An off-by-one in the width count, in the shift amount or in the strict-versus-inclusive comparisons moves that edge by one cycle at the window borders, and the check then fails. Separate checks hold a request with no measured period and with only the wrong-direction bypass set. A design that times out or mixes up the two bypass bits would grant there. The bench also sweeps the hold count, which catches grants that are one cycle short or long.

// File: rtl/esg_pkg.sv
package esg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } accState_e;

  typedef struct packed {
    logic loadTimer;
    logic decTimer;
  } ctrlStrobe_t;

  localparam int FAST_WR_BIT = 29;
  localparam int FAST_RD_BIT = 28;
  localparam int CODE_LSB    = 16;

endpackage

// File: rtl/esg_regs.sv
module esg_regs #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int TIME_W  = 16,
  parameter int RATIO_W = 4,
  parameter int OFS_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               apbSel,
  input  logic               apbEnable,
  input  logic               apbWrite,
  input  logic [ADDR_W-1:0]  apbAddr,
  input  logic [DATA_W-1:0]  apbWdata,
  output logic [DATA_W-1:0]  apbRdata,
  output logic               fastWr,
  output logic               fastRd,
  output logic [TIME_W-1:0]  holdTime,
  output logic [RATIO_W-1:0] preCode,
  output logic [OFS_W-1:0]   preOfs,
  output logic [RATIO_W-1:0] postCode,
  output logic [OFS_W-1:0]   postOfs
);
  import esg_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_CFG  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_POST = IDX_W'(3);

  logic [IDX_W-1:0] wordIdx;
  logic             wrEn;

  assign wordIdx = apbAddr[ADDR_W-1:2];
  assign wrEn    = apbSel && apbEnable && apbWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastWr   <= 1'b0;
      fastRd   <= 1'b0;
      holdTime <= '0;
      preCode  <= '0;
      preOfs   <= '0;
      postCode <= '0;
      postOfs  <= '0;
    end else if (wrEn) begin
      if (wordIdx == IDX_CFG) begin
        fastWr   <= apbWdata[FAST_WR_BIT];
        fastRd   <= apbWdata[FAST_RD_BIT];
        holdTime <= apbWdata[TIME_W-1:0];
      end
      if (wordIdx == IDX_PRE) begin
        preCode <= apbWdata[CODE_LSB +: RATIO_W];
        preOfs  <= apbWdata[OFS_W-1:0];
      end
      if (wordIdx == IDX_POST) begin
        postCode <= apbWdata[CODE_LSB +: RATIO_W];
        postOfs  <= apbWdata[OFS_W-1:0];
      end
    end
  end

  always_comb begin
    apbRdata = '0;
    if (apbSel) begin
      if (wordIdx == IDX_CFG) begin
        apbRdata[FAST_WR_BIT]  = fastWr;
        apbRdata[FAST_RD_BIT]  = fastRd;
        apbRdata[TIME_W-1:0]   = holdTime;
      end else if (wordIdx == IDX_PRE) begin
        apbRdata[CODE_LSB +: RATIO_W] = preCode;
        apbRdata[OFS_W-1:0]           = preOfs;
      end else if (wordIdx == IDX_POST) begin
        apbRdata[CODE_LSB +: RATIO_W] = postCode;
        apbRdata[OFS_W-1:0]           = postOfs;
      end
    end
  end

endmodule

// File: rtl/esg_datapath.sv
module esg_datapath #(
  parameter int CNT_W   = 32,
  parameter int TIME_W  = 16,
  parameter int RATIO_W = 4,
  parameter int OFS_W   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 slowLvl,
  input  logic [TIME_W-1:0]    holdTime,
  input  logic [RATIO_W-1:0]   preCode,
  input  logic [OFS_W-1:0]     preOfs,
  input  logic [RATIO_W-1:0]   postCode,
  input  logic [OFS_W-1:0]     postOfs,
  input  esg_pkg::ctrlStrobe_t strobe,
  output logic                 windowOk,
  output logic                 timerZero
);

  localparam int W1         = CNT_W + 1;
  localparam int W2         = CNT_W + 2;
  localparam int SHIFT_BASE = 2 ** RATIO_W;
  localparam int SIDES      = 2;

  logic              lvlQ;
  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  lowWidth;
  logic [CNT_W-1:0]  highWidth;
  logic [CNT_W-1:0]  sinceRise;
  logic [TIME_W-1:0] holdCnt;

  logic [CNT_W-1:0]   sideWidth [SIDES];
  logic [RATIO_W-1:0] sideCode  [SIDES];
  logic [OFS_W-1:0]   sideOfs   [SIDES];
  logic [W1-1:0]      sideGuard [SIDES];

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] ratioTerm(input logic [CNT_W-1:0] w,
                                                 input logic [RATIO_W-1:0] code);
    if (code == '0) return '0;
    return w >> (SHIFT_BASE - int'(code));
  endfunction

  // width measurement on the synchronized slow level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ      <= 1'b0;
      phaseCnt  <= '0;
      lowWidth  <= '0;
      highWidth <= '0;
      sinceRise <= '0;
    end else if (slowLvl != lvlQ) begin
      lvlQ     <= slowLvl;
      phaseCnt <= '0;
      if (slowLvl) begin
        lowWidth  <= satInc(phaseCnt);
        sinceRise <= '0;
      end else begin
        highWidth <= satInc(phaseCnt);
        sinceRise <= satInc(sinceRise);
      end
    end else begin
      phaseCnt  <= satInc(phaseCnt);
      sinceRise <= satInc(sinceRise);
    end
  end

  // side 0: before the rising edge, side 1: after it
  assign sideWidth[0] = lowWidth;
  assign sideWidth[1] = highWidth;
  assign sideCode[0]  = preCode;
  assign sideCode[1]  = postCode;
  assign sideOfs[0]   = preOfs;
  assign sideOfs[1]   = postOfs;

  for (genvar g = 0; g < SIDES; g++) begin : g_guard
    assign sideGuard[g] = W1'(ratioTerm(sideWidth[g], sideCode[g])) + W1'(sideOfs[g]);
  end

  logic [W1-1:0] period;
  logic [W1-1:0] sinceExt;
  logic [W1-1:0] remaining;
  logic [W2-1:0] needed;

  always_comb begin
    period    = W1'(lowWidth) + W1'(highWidth);
    sinceExt  = W1'(sinceRise);
    remaining = (period > sinceExt) ? (period - sinceExt) : '0;
    needed    = W2'(sideGuard[0]) + W2'(holdTime);
    windowOk  = (W2'(remaining) > needed) && (sinceExt >= sideGuard[1]);
  end

  // hold timer for the access strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.loadTimer) begin
      holdCnt <= holdTime;
    end else if (strobe.decTimer) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign timerZero = (holdCnt == '0);

endmodule

// File: rtl/esg_ctrl.sv
module esg_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accReq,
  input  logic                 accWrite,
  input  logic                 fastWr,
  input  logic                 fastRd,
  input  logic                 windowOk,
  input  logic                 timerZero,
  output esg_pkg::ctrlStrobe_t strobe,
  output logic                 accGrant,
  output logic                 accDone
);
  import esg_pkg::*;

  accState_e state;
  accState_e stateNext;
  logic      bypass;
  logic      startAcc;

  assign bypass   = accWrite ? fastWr : fastRd;
  assign startAcc = accReq && (bypass || windowOk);

  always_comb begin
    stateNext        = state;
    strobe.loadTimer = 1'b0;
    strobe.decTimer  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startAcc) begin
          stateNext        = ST_ACTIVE;
          strobe.loadTimer = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (timerZero) stateNext = ST_DONE;
        else           strobe.decTimer = 1'b1;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign accGrant = (state == ST_ACTIVE);
  assign accDone  = (state == ST_DONE);

endmodule

// File: rtl/edge_guard_sched.sv
module edge_guard_sched #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32,
  parameter int TIME_W  = 16,
  parameter int RATIO_W = 4,
  parameter int OFS_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic [DATA_W-1:0] apbWdata,
  output logic [DATA_W-1:0] apbRdata,
  input  logic              slowLvl,
  input  logic              accReq,
  input  logic              accWrite,
  output logic              accGrant,
  output logic              accDone
);
  import esg_pkg::*;

  logic               fastWr;
  logic               fastRd;
  logic [TIME_W-1:0]  holdTime;
  logic [RATIO_W-1:0] preCode;
  logic [OFS_W-1:0]   preOfs;
  logic [RATIO_W-1:0] postCode;
  logic [OFS_W-1:0]   postOfs;
  logic               windowOk;
  logic               timerZero;
  ctrlStrobe_t        strobe;

  esg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W),
    .RATIO_W(RATIO_W), .OFS_W(OFS_W)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbAddr(apbAddr), .apbWdata(apbWdata), .apbRdata(apbRdata),
    .fastWr(fastWr), .fastRd(fastRd), .holdTime(holdTime),
    .preCode(preCode), .preOfs(preOfs), .postCode(postCode), .postOfs(postOfs)
  );

  esg_datapath #(
    .CNT_W(CNT_W), .TIME_W(TIME_W), .RATIO_W(RATIO_W), .OFS_W(OFS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .slowLvl(slowLvl), .holdTime(holdTime),
    .preCode(preCode), .preOfs(preOfs), .postCode(postCode), .postOfs(postOfs),
    .strobe(strobe), .windowOk(windowOk), .timerZero(timerZero)
  );

  esg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accReq(accReq), .accWrite(accWrite),
    .fastWr(fastWr), .fastRd(fastRd), .windowOk(windowOk), .timerZero(timerZero),
    .strobe(strobe), .accGrant(accGrant), .accDone(accDone)
  );

endmodule

// File: rtl/edge_guard_sched_chk.sv
module edge_guard_sched_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              apbSel,
  input logic [ADDR_W-1:0] apbAddr,
  input logic [DATA_W-1:0] apbRdata,
  input logic              accReq,
  input logic              accGrant,
  input logic              accDone,
  input logic [TIME_W-1:0] holdTime
);

  logic [TIME_W:0] grantLen;

  always_ff @(posedge clk) begin
    if (!rstN)         grantLen <= '0;
    else if (accGrant) grantLen <= grantLen + 1'b1;
    else               grantLen <= '0;
  end

  // R2: reserved word reads zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && apbAddr[ADDR_W-1:2] == (ADDR_W-2)'(1)) |-> (apbRdata == '0));

  // R6: a grant never starts without a request
  p_grant_from_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accGrant) |-> $past(accReq));

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> !accDone);

  // R9: grant and done never overlap
  p_grant_done_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(accGrant && accDone));

  // R9: done follows the end of a grant
  p_done_after_grant_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accDone) |-> $past(accGrant));

  // R9: grant is never held beyond hold count + 1 cycles
  p_grant_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (grantLen <= {1'b0, holdTime}));

endmodule

bind edge_guard_sched edge_guard_sched_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W)
) u_chk (
  .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbAddr(apbAddr),
  .apbRdata(apbRdata), .accReq(accReq), .accGrant(accGrant),
  .accDone(accDone), .holdTime(holdTime)
);

// File: tb/edge_guard_sched_bench.sv
module edge_guard_sched_bench;

  localparam int LOW_W  = 40;
  localparam int HIGH_W = 24;
  localparam int PER    = LOW_W + HIGH_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        apbSel = 1'b0;
  logic        apbEnable = 1'b0;
  logic        apbWrite = 1'b0;
  logic [3:0]  apbAddr = '0;
  logic [31:0] apbWdata = '0;
  logic [31:0] apbRdata;
  logic        slowLvl = 1'b0;
  logic        accReq = 1'b0;
  logic        accWrite = 1'b0;
  logic        accGrant;
  logic        accDone;

  int  nCyc = 0;
  int  base = 0;
  bit  slowRun = 1'b0;
  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  edge_guard_sched u_edge_guard_sched (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbAddr(apbAddr), .apbWdata(apbWdata),
    .apbRdata(apbRdata), .slowLvl(slowLvl), .accReq(accReq),
    .accWrite(accWrite), .accGrant(accGrant), .accDone(accDone)
  );

  // after tick: last posedge index = nCyc-2, next posedge index = nCyc-1
  task automatic tick();
    @(negedge clk);
    slowLvl = slowRun ? (((nCyc - base) % PER) >= LOW_W) : 1'b0;
    nCyc++;
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apbWr(input logic [3:0] a, input logic [31:0] d);
    apbSel = 1'b1; apbWrite = 1'b1; apbAddr = a; apbWdata = d; apbEnable = 1'b0;
    tick();
    apbEnable = 1'b1;
    tick();
    apbSel = 1'b0; apbEnable = 1'b0; apbWrite = 1'b0;
  endtask

  task automatic apbRd(input logic [3:0] a, output logic [31:0] d);
    apbSel = 1'b1; apbWrite = 1'b0; apbAddr = a; apbEnable = 1'b0;
    tick();
    d = apbRdata;
    apbSel = 1'b0;
  endtask

  function automatic int guardOf(input int width, input int code, input int ofs);
    return ((code == 0) ? 0 : (width >> (16 - code))) + ofs;
  endfunction

  // wait for grant, check start edge, length and done pulse (R9)
  task automatic runAccess(input int expEdge, input int hold, input string tag);
    int g = -1;
    int len;
    for (int w = 0; w < 4 * PER; w++) begin
      tick();
      if (accGrant) begin g = nCyc - 2; break; end
    end
    accReq = 1'b0;
    check(g == expEdge, tag, g, expEdge);
    len = 1;
    for (int w = 0; w < hold + 4; w++) begin
      tick();
      if (accGrant) len++;
      else break;
    end
    check(len == hold + 1 && accDone, "R9 grant length then done", len, hold + 1);
    tick();
    check(!accDone && !accGrant, "R9 done single cycle", accDone, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R3: reset values
    for (int i = 0; i < 4; i++) begin
      apbRd(4'(i * 4), rd);
      check(rd == 0, "R3 register reset value", rd, 0);
    end
    check(!accGrant && !accDone, "R3 grant/done low after reset", {accGrant, accDone}, 0);

    // R1, R2: field masks and reserved word
    for (int i = 0; i < 4; i++) apbWr(4'(i * 4), 32'hFFFF_FFFF);
    apbRd(4'h0, rd); check(rd == 32'h3000_FFFF, "R1 config word mask", rd, 32'h3000_FFFF);
    apbRd(4'h4, rd); check(rd == 32'h0, "R2 reserved word reads zero", rd, 0);
    apbRd(4'h8, rd); check(rd == 32'h000F_FFFF, "R1 pre-edge word mask", rd, 32'h000F_FFFF);
    apbRd(4'hC, rd); check(rd == 32'h000F_FFFF, "R1 post-edge word mask", rd, 32'h000F_FFFF);
    apbWr(4'h0, 32'h0); apbWr(4'h8, 32'h0); apbWr(4'hC, 32'h0);
    apbWr(4'h4, 32'hFFFF_FFFF);
    apbRd(4'h0, rd); check(rd == 0, "R2 reserved write leaves config", rd, 0);
    apbRd(4'h8, rd); check(rd == 0, "R2 reserved write leaves pre-edge", rd, 0);
    apbRd(4'hC, rd); check(rd == 0, "R2 reserved write leaves post-edge", rd, 0);

    // R7: no measured period, request stays pending
    accWrite = 1'b0; accReq = 1'b1;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 300; i++) begin tick(); if (accGrant) seen = 1'b1; end
      check(!seen, "R7 pending without window", seen, 0);
      // R8: write bypass does not release a read
      apbWr(4'h0, (32'h1 << 29) | 32'd3);
      for (int i = 0; i < 30; i++) begin tick(); if (accGrant) seen = 1'b1; end
      check(!seen, "R8 write bypass ignored for read", seen, 0);
    end
    // R8: read bypass releases the pending read at the next edge
    apbWr(4'h0, (32'h1 << 28) | 32'd3);
    runAccess(nCyc - 1, 3, "R8 read bypass grants at once");

    // R8, R9: write bypass sweep over hold counts
    for (int t = 0; t < 6; t++) begin
      apbWr(4'h0, (32'h1 << 29) | 32'(t));
      tick();
      accWrite = 1'b1; accReq = 1'b1; n0 = nCyc - 1;
      runAccess(n0, t, "R8 write bypass grants at once");
    end
    apbWr(4'h0, 32'h0);

    // start slow clock and let widths settle
    slowRun = 1'b1; base = nCyc;
    repeat (3 * PER + 5) tick();

    // R4, R5, R6: window placement sweep over all phases
    for (int c = 0; c < 5; c++) begin
      int pc, po, qc, qo, hold, preG, postG;
      bit rdBypass;
      case (c)
        0: begin pc = 14; po = 3; qc = 13; qo = 2; hold = 4; rdBypass = 0; end
        1: begin pc = 0;  po = 0; qc = 0;  qo = 0; hold = 0; rdBypass = 0; end
        2: begin pc = 15; po = 0; qc = 15; qo = 1; hold = 7; rdBypass = 0; end
        3: begin pc = 1;  po = 10; qc = 1; qo = 10; hold = 2; rdBypass = 0; end
        default: begin pc = 15; po = 0; qc = 15; qo = 1; hold = 7; rdBypass = 1; end
      endcase
      preG  = guardOf(LOW_W, pc, po);
      postG = guardOf(HIGH_W, qc, qo);
      apbWr(4'h8, (32'(pc) << 16) | 32'(po));
      apbWr(4'hC, (32'(qc) << 16) | 32'(qo));
      apbWr(4'h0, (32'(rdBypass) << 28) | 32'(hold));
      for (int ph = 0; ph < PER; ph++) begin
        int m, s;
        tick();
        while (((nCyc - 1 - base) % PER) != ph) tick();
        accWrite = rdBypass ? 1'b0 : ph[0];
        accReq = 1'b1; n0 = nCyc - 1;
        m = n0;
        if (!rdBypass) begin
          for (int k = 0; k < 2 * PER; k++) begin
            s = (m - 1 - base - LOW_W) % PER;
            if ((PER - s > preG + hold) && (s >= postG)) break;
            m++;
          end
        end
        runAccess(m, hold, rdBypass ? "R8 read bypass in measured mode"
                                    : "R6 window start edge (R4 widths, R5 guards)");
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule